// File: doc/BRIEF.md
# Handshake Line Qualifier for a Serial Channel

This block sits beside the receive and transmit engines of one serial channel and decides, from two asynchronous handshake inputs, when each engine may run. The carrier input gates the receiver and the clear input gates the transmitter. Each input first passes through a multi-flop synchronizer with edge detection. It is then qualified under its own mode bit:

- **Envelope mode.** The line must stay high across the whole frame. Losing it while the engine reports an open frame latches a sticky lost error.
- **Pulse mode.** The first rising edge after the direction is enabled latches synchronization. Later activity on the line is then ignored.

The block also registers the per-direction transparent selections and forwards them to the engines, independent of the protocol field. It checks the configuration for an illegal combination. When that combination is present, it raises a configuration error and forces both enables low.

Top module: `sync_line_qual`

## Requirements
- R1: A change on a handshake input reaches the qualifier state on the third rising clock edge after it is applied, and not before.
- R2: In envelope mode (pulse-mode bit 0), with the direction enabled and no configuration error, the direction's enable output follows the synchronized line level.
- R3: In envelope mode, a falling edge of the synchronized line while the matching frame-active input is 1 and the direction is enabled sets the lost-error output. A falling edge while frame-active is 0 drops the enable without raising an error.
- R4: A lost-error output stays set until its clear input is 1 at a clock edge. If a new loss and a clear occur at the same edge, the loss wins and the flag stays 1.
- R5: In pulse mode (pulse-mode bit 1), the first synchronized rising edge sets the synced output and the enable. Later transitions on that line change neither output and never raise a lost error.
- R6: Pulse-mode synchronization is cleared one edge after the direction-enable input is 0. A line that is already high when the direction is re-enabled does not count as a rising edge.
- R7: The transmit and receive transparent outputs equal the corresponding select inputs one clock later, whatever the protocol field holds.
- R8: When the 2-bit protocol field equals 2'b10 (Ethernet) and the two transparent selects differ, the configuration-error output is 1 one clock later and both enables are 0. In every other configuration the error output is 0.
- R9: With the direction-enable input at 0, that direction's enable and synced outputs are 0 in both modes.
- R10: While the synchronous active-low reset is 0, every output is 0 after a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_carrier_in | input | 1 | Asynchronous carrier handshake for the receiver |
| tx_clear_in | input | 1 | Asynchronous clear handshake for the transmitter |
| rx_pulse_mode | input | 1 | 1: receive line is a one-shot sync pulse; 0: envelope |
| tx_pulse_mode | input | 1 | 1: transmit line is a one-shot sync pulse; 0: envelope |
| rx_dir_en | input | 1 | Receive direction enabled |
| tx_dir_en | input | 1 | Transmit direction enabled |
| rx_frame_active | input | 1 | Receive engine is inside a frame |
| tx_frame_active | input | 1 | Transmit engine is inside a frame |
| rx_lost_clr | input | 1 | Write-one-to-clear for the receive lost error |
| tx_lost_clr | input | 1 | Write-one-to-clear for the transmit lost error |
| proto_sel | input | 2 | Protocol field, 2'b10 = Ethernet |
| tx_transp_sel | input | 1 | Transmitter transparent select |
| rx_transp_sel | input | 1 | Receiver transparent select |
| rx_enable | output | 1 | Receiver may proceed |
| tx_enable | output | 1 | Transmitter may proceed |
| rx_synced | output | 1 | Receive qualifier state (level or latched pulse) |
| tx_synced | output | 1 | Transmit qualifier state (level or latched pulse) |
| rx_lost_err | output | 1 | Sticky receive line-lost error |
| tx_lost_err | output | 1 | Sticky transmit line-lost error |
| rx_transparent | output | 1 | Registered receive transparent select |
| tx_transparent | output | 1 | Registered transmit transparent select |
| cfg_err | output | 1 | Illegal Ethernet/transparency configuration |

## Verification
The bench applies several kinds of line activity:

- **Step edges.** A single step on a line measures the synchronizer latency exactly.
- **Envelope drops.** Drops inside and outside a frame separate a real loss from an ordinary end of carrier.
- **Pulse trains.** Short pulses and repeated toggles in pulse mode show that only the first edge counts. A line held high across a disable and re-enable shows that a level is not taken for an edge.
- **Configuration sweep.** Sweeping the protocol field against the transparent selects separates the one illegal combination from the legal ones.

A long stretch of random line, frame, clear and configuration activity is then compared against a behavioural model on every cycle.

// File: rtl/syncq_pkg.sv
// Package: shared constants and types for the handshake line qualifier.
// Assumes direction index 0 is receive (carrier) and 1 is transmit (clear).
package syncq_pkg;
    localparam int NUM_DIR = 2;
    localparam int DIR_RX  = 0;
    localparam int DIR_TX  = 1;

    typedef enum logic [1:0] {
        PROTO_HDLC   = 2'b00,
        PROTO_ASYNC  = 2'b01,
        PROTO_ETHER  = 2'b10,
        PROTO_BISYNC = 2'b11
    } proto_e;
endpackage

// File: rtl/hs_sync.sv
// Module: hs_sync
// Brings one asynchronous handshake line into the clock domain through a
// STAGES-deep flop chain, keeps one extra delayed copy and derives rise and
// fall pulses from the pair. Assumes the line is quasi-static versus clk.
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], line_in};
    end

    // Keep the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;
    assign fall  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/line_qualifier.sv
// Module: line_qualifier
// Per-direction qualification. In envelope mode the synced state tracks the
// synchronized level; in pulse mode it latches on the first rising edge and
// holds until the direction is disabled. Sets a sticky lost flag on a
// mid-frame negation in envelope mode. Assumes rise/fall come from hs_sync.
module line_qualifier (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise,
    input  logic fall,
    input  logic pulse_mode,
    input  logic dir_en,
    input  logic frame_active,
    input  logic lost_clr,
    output logic synced,
    output logic lost_err
);
    logic sync_q;
    logic lost_q;
    logic sync_d;
    logic loss_evt;

    // Next synced state: level-following or edge-latched.
    always_comb begin
        if (pulse_mode) sync_d = dir_en & (sync_q | rise);
        else            sync_d = dir_en & level;
    end

    assign loss_evt = ~pulse_mode & dir_en & frame_active & fall;

    // Register the qualifier state.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_d;
    end

    // Sticky lost flag; a new loss takes priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        lost_q <= 1'b0;
        else if (loss_evt) lost_q <= 1'b1;
        else if (lost_clr) lost_q <= 1'b0;
    end

    assign synced   = sync_q;
    assign lost_err = lost_q;

    // R3: a loss can only appear when a frame was open in envelope mode.
    p_loss_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_q) |-> $past(frame_active && !pulse_mode && dir_en));

    // R4: the flag stays set unless a clear was seen.
    p_lost_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_q && !lost_clr) |=> lost_q);

    // R5: a latched pulse sync holds while the direction remains enabled.
    p_pulse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && pulse_mode && dir_en) |=> sync_q);

    // R9: a disabled direction is never synced on the next cycle.
    p_disabled_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_en |=> !sync_q);
endmodule

// File: rtl/cfg_check.sv
// Module: cfg_check
// Registers the transparent selects and flags the illegal combination of an
// Ethernet protocol field with differing transparent selects.
// Assumes the configuration changes only rarely and needs no synchronizer.
module cfg_check
    import syncq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] proto_sel,
    input  logic       tx_transp_sel,
    input  logic       rx_transp_sel,
    output logic       tx_transp,
    output logic       rx_transp,
    output logic       cfg_err
);
    logic tx_q;
    logic rx_q;
    logic err_q;
    logic is_ether;

    assign is_ether = (proto_e'(proto_sel) == PROTO_ETHER);

    // Register selects and the consistency result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= 1'b0;
            rx_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            tx_q  <= tx_transp_sel;
            rx_q  <= rx_transp_sel;
            err_q <= is_ether & (tx_transp_sel ^ rx_transp_sel);
        end
    end

    assign tx_transp = tx_q;
    assign rx_transp = rx_q;
    assign cfg_err   = err_q;

    // R8: an illegal configuration is flagged on the following cycle.
    p_cfg_detect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_sel == 2'b10 && tx_transp_sel != rx_transp_sel) |=> cfg_err);

    // R7: the transmit transparent output follows its select.
    p_transp_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_q) |-> $past(tx_transp_sel));
endmodule

// File: rtl/sync_line_qual.sv
// Module: sync_line_qual (top)
// Builds one synchronizer and one qualifier per direction, plus the
// configuration checker, and gates the enables with the configuration error.
// Assumes index 0 = receive/carrier, index 1 = transmit/clear.
module sync_line_qual
    import syncq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_carrier_in,
    input  logic       tx_clear_in,
    input  logic       rx_pulse_mode,
    input  logic       tx_pulse_mode,
    input  logic       rx_dir_en,
    input  logic       tx_dir_en,
    input  logic       rx_frame_active,
    input  logic       tx_frame_active,
    input  logic       rx_lost_clr,
    input  logic       tx_lost_clr,
    input  logic [1:0] proto_sel,
    input  logic       tx_transp_sel,
    input  logic       rx_transp_sel,
    output logic       rx_enable,
    output logic       tx_enable,
    output logic       rx_synced,
    output logic       tx_synced,
    output logic       rx_lost_err,
    output logic       tx_lost_err,
    output logic       rx_transparent,
    output logic       tx_transparent,
    output logic       cfg_err
);
    logic [NUM_DIR-1:0] line_v, pulse_v, en_v, frame_v, clr_v;
    logic [NUM_DIR-1:0] lvl_v, rise_v, fall_v, sync_v, lost_v;

    assign line_v  = {tx_clear_in, rx_carrier_in};
    assign pulse_v = {tx_pulse_mode, rx_pulse_mode};
    assign en_v    = {tx_dir_en, rx_dir_en};
    assign frame_v = {tx_frame_active, rx_frame_active};
    assign clr_v   = {tx_lost_clr, rx_lost_clr};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_in(line_v[d]),
            .level  (lvl_v[d]),
            .rise   (rise_v[d]),
            .fall   (fall_v[d])
        );
        line_qualifier u_qual (
            .clk         (clk),
            .rst_n       (rst_n),
            .level       (lvl_v[d]),
            .rise        (rise_v[d]),
            .fall        (fall_v[d]),
            .pulse_mode  (pulse_v[d]),
            .dir_en      (en_v[d]),
            .frame_active(frame_v[d]),
            .lost_clr    (clr_v[d]),
            .synced      (sync_v[d]),
            .lost_err    (lost_v[d])
        );
    end

    cfg_check u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .proto_sel    (proto_sel),
        .tx_transp_sel(tx_transp_sel),
        .rx_transp_sel(rx_transp_sel),
        .tx_transp    (tx_transparent),
        .rx_transp    (rx_transparent),
        .cfg_err      (cfg_err)
    );

    assign rx_synced   = sync_v[DIR_RX];
    assign tx_synced   = sync_v[DIR_TX];
    assign rx_lost_err = lost_v[DIR_RX];
    assign tx_lost_err = lost_v[DIR_TX];
    assign rx_enable   = sync_v[DIR_RX] & ~cfg_err;
    assign tx_enable   = sync_v[DIR_TX] & ~cfg_err;

    // R2: in envelope mode an enabled receiver follows the line seen earlier.
    p_env_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_dir_en) && !$past(rx_pulse_mode) && !rx_synced)
        |-> !$past(lvl_v[DIR_RX]));
endmodule

// File: tb/sim_sync_line_qual.sv
module sim_sync_line_qual;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_carrier_in = 0, tx_clear_in = 0;
    logic rx_pulse_mode = 0, tx_pulse_mode = 0;
    logic rx_dir_en = 0, tx_dir_en = 0;
    logic rx_frame_active = 0, tx_frame_active = 0;
    logic rx_lost_clr = 0, tx_lost_clr = 0;
    logic [1:0] proto_sel = 2'b00;
    logic tx_transp_sel = 0, rx_transp_sel = 0;
    logic rx_enable, tx_enable, rx_synced, tx_synced;
    logic rx_lost_err, tx_lost_err, rx_transparent, tx_transparent, cfg_err;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sync_line_qual u0 (.*);

    // Behavioural reference model: per-direction sample histories and state.
    bit hist_rx[$];
    bit hist_tx[$];
    bit m_sync[2];
    bit m_lost[2];
    bit m_cfg, m_ttx, m_trx;

    task automatic model_dir(input int d, input bit line, input bit pm,
                             input bit en, input bit fa, input bit clr);
        bit lvl, prv, rs, fl;
        if (d == 0) begin lvl = hist_rx[1]; prv = hist_rx[2]; end
        else        begin lvl = hist_tx[1]; prv = hist_tx[2]; end
        rs = lvl && !prv;
        fl = !lvl && prv;
        if (!pm && en && fa && fl) m_lost[d] = 1;
        else if (clr)              m_lost[d] = 0;
        if (pm) m_sync[d] = en && (m_sync[d] || rs);
        else    m_sync[d] = en && lvl;
        if (d == 0) begin hist_rx.push_front(line); void'(hist_rx.pop_back()); end
        else        begin hist_tx.push_front(line); void'(hist_tx.pop_back()); end
    endtask

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            hist_rx = '{0, 0, 0};
            hist_tx = '{0, 0, 0};
            m_sync = '{0, 0};
            m_lost = '{0, 0};
            m_cfg = 0; m_ttx = 0; m_trx = 0;
        end else begin
            model_dir(0, rx_carrier_in, rx_pulse_mode, rx_dir_en, rx_frame_active, rx_lost_clr);
            model_dir(1, tx_clear_in, tx_pulse_mode, tx_dir_en, tx_frame_active, tx_lost_clr);
            m_cfg = (proto_sel == 2'b10) && (tx_transp_sel != rx_transp_sel);
            m_ttx = tx_transp_sel;
            m_trx = rx_transp_sel;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R2 rx_enable model", rx_enable, m_sync[0] && !m_cfg);
            chk("R2 tx_enable model", tx_enable, m_sync[1] && !m_cfg);
            chk("R5 rx_synced model", rx_synced, m_sync[0]);
            chk("R5 tx_synced model", tx_synced, m_sync[1]);
            chk("R3 rx_lost model", rx_lost_err, m_lost[0]);
            chk("R3 tx_lost model", tx_lost_err, m_lost[1]);
            chk("R7 rx_transparent model", rx_transparent, m_trx);
            chk("R7 tx_transparent model", tx_transparent, m_ttx);
            chk("R8 cfg_err model", cfg_err, m_cfg);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        // R10: reset state
        chk("R10 rx_enable reset", rx_enable, 0);
        chk("R10 tx_enable reset", tx_enable, 0);
        chk("R10 lost reset", rx_lost_err | tx_lost_err, 0);
        chk("R10 cfg_err reset", cfg_err, 0);
        rst_n = 1;
        cyc(2);
        // R1 / R2: latency of an envelope step
        rx_dir_en = 1; rx_carrier_in = 1;
        cyc(2);
        chk("R1 rx_enable before third edge", rx_enable, 0);
        cyc(1);
        chk("R1 R2 rx_enable after third edge", rx_enable, 1);
        // R3: loss inside a frame
        rx_frame_active = 1; rx_carrier_in = 0;
        cyc(3);
        chk("R3 rx_lost in frame", rx_lost_err, 1);
        chk("R3 rx_enable dropped", rx_enable, 0);
        rx_frame_active = 0;
        // R4: sticky until clear
        cyc(5);
        chk("R4 rx_lost sticky", rx_lost_err, 1);
        rx_lost_clr = 1; cyc(1); rx_lost_clr = 0;
        chk("R4 rx_lost cleared", rx_lost_err, 0);
        // R3: drop between frames raises nothing
        rx_carrier_in = 1; cyc(4);
        rx_carrier_in = 0; cyc(4);
        chk("R3 no loss between frames", rx_lost_err, 0);
        chk("R3 enable drops between frames", rx_enable, 0);
        // R4: loss and clear at the same edge
        rx_carrier_in = 1; cyc(4);
        rx_frame_active = 1; rx_carrier_in = 0;
        cyc(2);
        rx_lost_clr = 1; cyc(1); rx_lost_clr = 0;
        chk("R4 set wins over clear", rx_lost_err, 1);
        rx_frame_active = 0;
        rx_lost_clr = 1; cyc(1); rx_lost_clr = 0;
        // R5: pulse mode
        tx_pulse_mode = 1; tx_dir_en = 1; tx_frame_active = 1;
        tx_clear_in = 1; cyc(1); tx_clear_in = 0;
        cyc(4);
        chk("R5 tx synced after pulse", tx_synced, 1);
        chk("R5 tx_enable after pulse", tx_enable, 1);
        for (int i = 0; i < 6; i++) begin tx_clear_in = ~tx_clear_in; cyc(2); end
        cyc(4);
        chk("R5 toggles ignored enable", tx_enable, 1);
        chk("R5 toggles no loss", tx_lost_err, 0);
        // R6: disable clears; held-high line is not an edge
        tx_clear_in = 1; cyc(4);
        tx_dir_en = 0; cyc(1);
        chk("R6 R9 tx sync cleared", tx_synced, 0);
        tx_dir_en = 1; cyc(5);
        chk("R6 level not an edge", tx_enable, 0);
        tx_clear_in = 0; cyc(3);
        tx_clear_in = 1; cyc(3);
        chk("R6 new edge resyncs", tx_enable, 1);
        // R8: illegal configuration
        proto_sel = 2'b10; tx_transp_sel = 1; rx_transp_sel = 0;
        cyc(1);
        chk("R8 cfg_err raised", cfg_err, 1);
        chk("R8 tx_enable forced low", tx_enable, 0);
        rx_transp_sel = 1; cyc(1);
        chk("R8 cfg_err legal duplex", cfg_err, 0);
        chk("R8 tx_enable restored", tx_enable, 1);
        // R7: transparency independent of protocol
        proto_sel = 2'b00; rx_transp_sel = 0; cyc(1);
        chk("R7 tx_transparent", tx_transparent, 1);
        chk("R7 rx_transparent", rx_transparent, 0);
        chk("R8 no error outside ethernet", cfg_err, 0);
        // R9: disabled envelope direction
        rx_carrier_in = 1; rx_dir_en = 0; cyc(4);
        chk("R9 rx_enable disabled", rx_enable, 0);
        chk("R9 rx_synced disabled", rx_synced, 0);
        // Random phase, compared cycle by cycle
        for (int i = 0; i < 600; i++) begin
            rx_carrier_in = ($urandom % 4) != 0 ? rx_carrier_in : ~rx_carrier_in;
            tx_clear_in = ($urandom % 4) != 0 ? tx_clear_in : ~tx_clear_in;
            rx_frame_active = $urandom % 2; tx_frame_active = $urandom % 2;
            rx_lost_clr = ($urandom % 8) == 0; tx_lost_clr = ($urandom % 8) == 0;
            rx_dir_en = ($urandom % 16) != 0; tx_dir_en = ($urandom % 16) != 0;
            if (($urandom % 32) == 0) begin
                rx_pulse_mode = $urandom % 2; tx_pulse_mode = $urandom % 2;
                proto_sel = 2'($urandom % 4);
                tx_transp_sel = $urandom % 2; rx_transp_sel = $urandom % 2;
            end
            cyc(1);
        end
        cyc(2);
        finish_run();
    end
endmodule